// File: doc/BRIEF.md
# Platform Interrupt Router

The block gathers a parameterised number of external interrupt inputs and steers them to a parameterised number of hart contexts. Every input passes through its own gateway, which turns a level or a rising edge into a single pending bit and keeps that bit from being raised again while the request is being serviced. Each context owns an enable bit for every source and a priority threshold, and it drives one registered interrupt line. Software on a context reads its claim register to learn which source to service, and writes the same source ID back when it has finished.

Sources are numbered from 1. ID 0 is reserved and means "nothing to service". Ties in priority go to the lower ID. A source is forwarded to a context only when its priority is strictly above that context's threshold, so priority 0 never interrupts. Edge inputs that arrive while their handler is running are counted up to a fixed limit when `QUEUE_EDGES` is 1 and discarded when it is 0. Contexts that are not fitted in a given build are cleared in the `CTX_PRESENT` mask.

Top module: `irq_hub`

## Requirements
- R1: After a synchronous reset all priorities, trigger modes, enables, thresholds, pending bits and service states are zero (every source level-triggered), and `irq_out` and `bus_rdata` are zero.
- R2: The address is {kind[11:9], context[8:5], source[4:0]}. Kind 0 is source priority, kind 1 is trigger mode (bit 0 set means edge), kind 2 is the pending bit (read only, writes do nothing), kind 3 is the enable bit, kind 4 is the context threshold, kind 5 is claim (read) and complete (write). Read data appears on `bus_rdata` in the cycle after `bus_rd` and is zero in any cycle after a cycle without `bus_rd`.
- R3: A pending source reaches a context only when that context's enable bit for it is set.
- R4: `irq_out[c]` is high, one cycle after the state that causes it, exactly when some pending source enabled for context c has priority strictly greater than that context's threshold.
- R5: A claim read returns the highest-priority qualifying source for the context, the lowest ID among equal priorities, and 0 when none qualifies.
- R6: A claim clears the winning source's pending bit in the same cycle and holds its gateway in service, so no new request from it becomes pending until its completion.
- R7: A completion write whose data names a source that is not in service, or not enabled for the writing context, changes nothing.
- R8: A level source becomes pending while its input is high and it is not in service; if the input is still high when its completion is written, it becomes pending again.
- R9: An edge source becomes pending on a rising edge of its input; further edges while it is pending but unclaimed merge into the same request.
- R10: With `QUEUE_EDGES`=1, rising edges that arrive while the source is in service are counted up to `QMAX`; each completion with a nonzero count makes the source pending again and takes one from the count.
- R11: With `QUEUE_EDGES`=0, rising edges that arrive while the source is in service are lost.
- R12: For a context cleared in `CTX_PRESENT`, `irq_out` stays low, its enable, threshold and claim registers read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_src | input | NSRC | Interrupt inputs, bit i is source i (indexed NSRC down to 1) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (claim side effect on kind 5) |
| bus_addr | input | 12 | Register address {kind, context, source} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq_out | output | NCTX | Registered interrupt line per context |

## Verification
The hard overlaps are a completion write landing in the same cycle as a rising edge on the source it releases, and a claim landing in the same cycle as a new edge or level on the source it takes. The bench drives such edges on exactly the completion and claim cycles while a behavioural model, written from the requirements, predicts each pending bit, each claim ID and each interrupt line on every clock. A second instance built with edge dropping receives the same stimulus, so the queue and drop policies are judged against one and the same edge pattern.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int KIND_W = 3;
  localparam int CTX_AW = 4;
  localparam int SRC_AW = 5;
  localparam int ADDR_W = KIND_W + CTX_AW + SRC_AW;
  localparam int DATA_W = 32;

  typedef enum logic [KIND_W-1:0] {
    K_PRIO  = 3'd0,
    K_TRIG  = 3'd1,
    K_PEND  = 3'd2,
    K_ENAB  = 3'd3,
    K_THRS  = 3'd4,
    K_CLAIM = 3'd5
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e         kind;
    logic [CTX_AW-1:0] ctx;
    logic [SRC_AW-1:0] src;
  } bus_addr_t;
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int QMAX  = 3,
  parameter bit QUEUE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic edge_mode,
  input  logic claim,
  input  logic complete,
  output logic pend,
  output logic busy
);
  localparam int CW = $clog2(QMAX + 1);

  logic          prev;
  logic          hit;
  logic          req;
  logic          busy_eff;
  logic          cnt_nz;
  logic          cnt_full;
  logic [CW-1:0] cnt;

  // rising edge only counts when the source is in edge mode
  assign hit      = edge_mode & irq_in & ~prev;
  assign req      = edge_mode ? hit : irq_in;
  // the completion cycle already counts as outside the handler
  assign busy_eff = busy & ~complete;
  assign cnt_nz   = (cnt != '0);
  assign cnt_full = (cnt == CW'(QMAX));

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= irq_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      if (complete) busy <= 1'b0;
      if (claim) begin
        pend <= 1'b0;
        busy <= 1'b1;
        if (QUEUE && hit && !cnt_full) cnt <= cnt + 1'b1;
      end else if (complete && cnt_nz) begin
        pend <= 1'b1;
        if (!hit) cnt <= cnt - 1'b1;
      end else if (req && !busy_eff && !pend) begin
        pend <= 1'b1;
      end else if (QUEUE && hit && busy_eff && !cnt_full) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  parameter int IDW    = 4
) (
  input  logic [NSRC:1]             pend,
  input  logic [NSRC:1]             en,
  input  logic [NSRC:1][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         thr,
  output logic [IDW-1:0]            win_id
);
  logic [PRIO_W-1:0] best;

  // the running best starts at the threshold: strict compare masks
  // equal priorities, priority zero, and later sources of equal rank
  always_comb begin
    best   = thr;
    win_id = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (pend[i] && en[i] && (prio[i] > best)) begin
        best   = prio[i];
        win_id = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int QMAX   = 3,
  parameter bit QUEUE_EDGES = 1'b1,
  parameter logic [NCTX-1:0] CTX_PRESENT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC:1]     irq_src,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCTX-1:0]   irq_out
);
  localparam int IDW = $clog2(NSRC + 1);

  bus_addr_t                   a;
  logic [NSRC:1][PRIO_W-1:0]   prio_q;
  logic [NSRC:1]               trig_q;
  logic [NSRC:1]               pend;
  logic [NSRC:1]               busy;
  logic [NSRC:1]               claim_vec;
  logic [NSRC:1]               cmp_vec;
  logic [NCTX-1:0][NSRC:1]     en_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;
  logic [NCTX-1:0][IDW-1:0]    win;
  logic                        ctx_ok;
  logic [IDW-1:0]              sel_win;
  logic [NSRC:1]               sel_en;
  logic [PRIO_W-1:0]           sel_thr;
  logic                        claim_go;
  logic [IDW-1:0]              claim_src;
  logic                        cmp_go;
  logic [DATA_W-1:0]           rd_val;

  assign a = bus_addr_t'(bus_addr);

  // context selection; absent or out-of-range contexts select zeros
  always_comb begin
    ctx_ok  = 1'b0;
    sel_win = '0;
    sel_en  = '0;
    sel_thr = '0;
    for (int c = 0; c < NCTX; c++) begin
      if (a.ctx == CTX_AW'(c) && CTX_PRESENT[c]) begin
        ctx_ok  = 1'b1;
        sel_win = win[c];
        sel_en  = en_q[c];
        sel_thr = thr_q[c];
      end
    end
  end

  assign claim_go  = bus_rd && (a.kind == K_CLAIM) && ctx_ok;
  assign claim_src = sel_win;
  assign cmp_go    = bus_wr && (a.kind == K_CLAIM) && ctx_ok;

  // per-source gateways with their claim / completion pulses
  for (genvar g = 1; g <= NSRC; g++) begin : g_src
    assign claim_vec[g] = claim_go && (claim_src == IDW'(g));
    assign cmp_vec[g]   = cmp_go && (bus_wdata == DATA_W'(g)) && busy[g] && sel_en[g];

    irq_gate #(
      .QMAX  (QMAX),
      .QUEUE (QUEUE_EDGES)
    ) u_gate (
      .clk       (clk),
      .rst       (rst),
      .irq_in    (irq_src[g]),
      .edge_mode (trig_q[g]),
      .claim     (claim_vec[g]),
      .complete  (cmp_vec[g]),
      .pend      (pend[g]),
      .busy      (busy[g])
    );
  end

  // per-context arbiters, only for fitted contexts
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    if (CTX_PRESENT[c]) begin : g_fit
      irq_pick #(
        .NSRC   (NSRC),
        .PRIO_W (PRIO_W),
        .IDW    (IDW)
      ) u_pick (
        .pend   (pend),
        .en     (en_q[c]),
        .prio   (prio_q),
        .thr    (thr_q[c]),
        .win_id (win[c])
      );
    end else begin : g_void
      assign win[c] = '0;
    end

    always_ff @(posedge clk) begin
      if (rst) irq_out[c] <= 1'b0;
      else     irq_out[c] <= CTX_PRESENT[c] && (win[c] != '0);
    end
  end

  // configuration writes
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
      trig_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (bus_wr) begin
      for (int i = 1; i <= NSRC; i++) begin
        if (a.src == SRC_AW'(i)) begin
          if (a.kind == K_PRIO) prio_q[i] <= bus_wdata[PRIO_W-1:0];
          if (a.kind == K_TRIG) trig_q[i] <= bus_wdata[0];
        end
      end
      for (int c = 0; c < NCTX; c++) begin
        if (a.ctx == CTX_AW'(c) && CTX_PRESENT[c]) begin
          if (a.kind == K_THRS) thr_q[c] <= bus_wdata[PRIO_W-1:0];
          for (int i = 1; i <= NSRC; i++) begin
            if (a.kind == K_ENAB && a.src == SRC_AW'(i)) en_q[c][i] <= bus_wdata[0];
          end
        end
      end
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    case (a.kind)
      K_PRIO: begin
        for (int i = 1; i <= NSRC; i++)
          if (a.src == SRC_AW'(i)) rd_val[PRIO_W-1:0] = prio_q[i];
      end
      K_TRIG: begin
        for (int i = 1; i <= NSRC; i++)
          if (a.src == SRC_AW'(i)) rd_val[0] = trig_q[i];
      end
      K_PEND: begin
        for (int i = 1; i <= NSRC; i++)
          if (a.src == SRC_AW'(i)) rd_val[0] = pend[i];
      end
      K_ENAB: begin
        for (int i = 1; i <= NSRC; i++)
          if (a.src == SRC_AW'(i)) rd_val[0] = sel_en[i];
      end
      K_THRS:  rd_val[PRIO_W-1:0] = sel_thr;
      K_CLAIM: rd_val[IDW-1:0]    = sel_win;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int NCTX = 2,
  parameter int IDW  = 4,
  parameter logic [NCTX-1:0] CTX_PRESENT = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NCTX-1:0]   irq_out,
  input logic [NSRC:1]     pend,
  input logic [NSRC:1]     busy,
  input logic              claim_go,
  input logic [IDW-1:0]    claim_src
);
  logic [KIND_W-1:0] kind_f;
  logic [CTX_AW-1:0] ctx_f;
  assign kind_f = bus_addr[ADDR_W-1 -: KIND_W];
  assign ctx_f  = bus_addr[SRC_AW +: CTX_AW];

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0)); // R2

  for (genvar i = 1; i <= NSRC; i++) begin : g_src
    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (rst)
      (claim_go && claim_src == IDW'(i)) |=> (!pend[i] && busy[i])); // R6
    AST_NO_PEND_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
      !(pend[i] && busy[i])); // R6
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    AST_LINE_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
      irq_out[c] |-> $past(|pend)); // R4
    if (!CTX_PRESENT[c]) begin : g_void
      AST_ABSENT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && ctx_f == CTX_AW'(c) && kind_f >= 3'd3 && kind_f <= 3'd5)
        |=> (bus_rdata == '0)); // R12
      AST_ABSENT_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd) |-> !irq_out[c]); // R12
    end
  end
endmodule

bind irq_hub irq_hub_chk #(
  .NSRC        (NSRC),
  .NCTX        (NCTX),
  .IDW         ($clog2(NSRC + 1)),
  .CTX_PRESENT (CTX_PRESENT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .pend      (pend),
  .busy      (busy),
  .claim_go  (claim_go),
  .claim_src (claim_src)
);

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;
  localparam int NSRC = 6;
  localparam int NCTX = 3;
  localparam int PRIO_W = 3;
  localparam int QMAX = 2;
  localparam logic [NCTX-1:0] PRESENT = 3'b101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NSRC:1] irq_src = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] d_rdata;
  logic [NCTX-1:0] irq_out;
  logic [NCTX-1:0] d_irq;

  always #2.5 clk = ~clk;

  irq_hub #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .QMAX(QMAX),
            .QUEUE_EDGES(1'b1), .CTX_PRESENT(PRESENT)) u_irq_hub (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  irq_hub #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .QMAX(QMAX),
            .QUEUE_EDGES(1'b0), .CTX_PRESENT(PRESENT)) u_irq_hub_drop (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(d_rdata), .irq_out(d_irq));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural model of the queueing instance
  int m_prio[NSRC+1], m_trig[NSRC+1], m_pend[NSRC+1], m_busy[NSRC+1];
  int m_cnt[NSRC+1], m_prev[NSRC+1];
  int m_en[NCTX][NSRC+1];
  int m_thr[NCTX], m_irq[NCTX];
  int m_rdata;

  function automatic int best_of(int c);
    int top = m_thr[c];
    int id = 0;
    if (!PRESENT[c]) return 0;
    for (int i = 1; i <= NSRC; i++)
      if (m_pend[i] != 0 && m_en[c][i] != 0 && m_prio[i] > top) begin
        top = m_prio[i];
        id = i;
      end
    return id;
  endfunction

  task automatic model_step();
    int win[NCTX];
    int k, c, s, cl, cm, nrd;
    bit cok;
    if (rst) begin
      for (int i = 0; i <= NSRC; i++) begin
        m_prio[i] = 0; m_trig[i] = 0; m_pend[i] = 0; m_busy[i] = 0; m_cnt[i] = 0; m_prev[i] = 0;
      end
      for (int x = 0; x < NCTX; x++) begin
        m_thr[x] = 0; m_irq[x] = 0;
        for (int i = 0; i <= NSRC; i++) m_en[x][i] = 0;
      end
      m_rdata = 0;
      return;
    end
    for (int x = 0; x < NCTX; x++) win[x] = best_of(x);
    k = int'(bus_addr[11:9]);
    c = int'(bus_addr[8:5]);
    s = int'(bus_addr[4:0]);
    cok = (c < NCTX) && PRESENT[c % NCTX];
    nrd = 0; cl = 0; cm = 0;
    if (bus_rd) begin
      case (k)
        0: if (s >= 1 && s <= NSRC) nrd = m_prio[s];
        1: if (s >= 1 && s <= NSRC) nrd = m_trig[s];
        2: if (s >= 1 && s <= NSRC) nrd = m_pend[s];
        3: if (cok && s >= 1 && s <= NSRC) nrd = m_en[c][s];
        4: if (cok) nrd = m_thr[c];
        5: if (cok) begin cl = win[c]; nrd = cl; end
        default: nrd = 0;
      endcase
    end
    if (bus_wr && k == 5 && cok) begin
      if (bus_wdata >= 1 && bus_wdata <= NSRC) begin
        int id = int'(bus_wdata);
        if (m_busy[id] != 0 && m_en[c][id] != 0) cm = id;
      end
    end
    for (int i = 1; i <= NSRC; i++) begin
      bit in = irq_src[i];
      bit rise = (m_trig[i] != 0) && in && (m_prev[i] == 0);
      bit want = (m_trig[i] != 0) ? rise : in;
      if (cl == i) begin
        m_pend[i] = 0; m_busy[i] = 1;
        if (rise && m_cnt[i] < QMAX) m_cnt[i]++;
      end else if (cm == i) begin
        m_busy[i] = 0;
        if (m_cnt[i] > 0) begin
          m_pend[i] = 1;
          if (!rise) m_cnt[i]--;
        end else if (want) m_pend[i] = 1;
      end else if (m_busy[i] == 0) begin
        if (want) m_pend[i] = 1;
      end else if (rise && m_cnt[i] < QMAX) begin
        m_cnt[i]++;
      end
      m_prev[i] = in;
    end
    if (bus_wr) begin
      if (s >= 1 && s <= NSRC) begin
        if (k == 0) m_prio[s] = int'(bus_wdata) % (1 << PRIO_W);
        if (k == 1) m_trig[s] = int'(bus_wdata[0]);
        if (k == 3 && cok) m_en[c][s] = int'(bus_wdata[0]);
      end
      if (k == 4 && cok) m_thr[c] = int'(bus_wdata) % (1 << PRIO_W);
    end
    for (int x = 0; x < NCTX; x++) m_irq[x] = (win[x] != 0) ? 1 : 0;
    m_rdata = nrd;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    for (int x = 0; x < NCTX; x++) chk("R4 model irq_out", int'(irq_out[x]), m_irq[x]);
    chk("R2 model bus_rdata", int'(bus_rdata), m_rdata);
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) tick();
  endtask

  task automatic wr(int k, int c, int s, int d);
    bus_addr = {3'(k), 4'(c), 5'(s)};
    bus_wdata = 32'(d);
    bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(int k, int c, int s, output int v, output int dv);
    bus_addr = {3'(k), 4'(c), 5'(s)};
    bus_rd = 1'b1;
    tick();
    v = int'(bus_rdata);
    dv = int'(d_rdata);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    irq_src = '0;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic pulse(int s);
    irq_src[s] = 1'b1;
    tick();
    irq_src[s] = 1'b0;
    tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, dv;
    do_reset();
    // R1 reset state
    chk("R1 irq_out", int'(irq_out), 0);
    chk("R1 bus_rdata", int'(bus_rdata), 0);
    rd(0, 0, 1, v, dv); chk("R1 prio", v, 0);
    rd(4, 0, 0, v, dv); chk("R1 threshold", v, 0);
    rd(1, 0, 3, v, dv); chk("R1 trigger", v, 0);

    // R2 register access, pending is read only
    wr(0, 0, 1, 5);
    rd(0, 0, 1, v, dv); chk("R2 prio readback", v, 5);
    wr(2, 0, 2, 1);
    rd(2, 0, 2, v, dv); chk("R2 pending read only", v, 0);
    idle(1); chk("R2 rdata idle", int'(bus_rdata), 0);

    // R3 enable gating
    irq_src[1] = 1'b1;
    idle(3);
    chk("R3 no enable no line", int'(irq_out[0]), 0);
    rd(2, 0, 1, v, dv); chk("R8 level pending", v, 1);
    wr(3, 0, 1, 1);
    idle(2);
    chk("R3 enabled line", int'(irq_out[0]), 1);
    chk("R3 other ctx quiet", int'(irq_out[2]), 0);

    // R4 strict threshold and priority zero
    wr(4, 0, 0, 5); idle(2);
    chk("R4 equal masked", int'(irq_out[0]), 0);
    wr(4, 0, 0, 4); idle(2);
    chk("R4 above passes", int'(irq_out[0]), 1);
    wr(4, 0, 0, 0); wr(0, 0, 1, 0); idle(2);
    chk("R4 prio zero", int'(irq_out[0]), 0);
    wr(0, 0, 1, 5);

    // R5 arbitration and tie order, R6/R7/R8 claim and completion
    wr(0, 0, 2, 6); wr(0, 0, 3, 6);
    wr(3, 0, 2, 1); wr(3, 0, 3, 1);
    irq_src[2] = 1'b1; irq_src[3] = 1'b1;
    idle(2);
    rd(5, 0, 0, v, dv); chk("R5 tie lowest id", v, 2);
    rd(2, 0, 2, v, dv); chk("R6 claim cleared pending", v, 0);
    rd(5, 0, 0, v, dv); chk("R5 next priority", v, 3);
    rd(5, 0, 0, v, dv); chk("R5 lower priority", v, 1);
    rd(5, 0, 0, v, dv); chk("R5 none left", v, 0);
    idle(2);
    rd(2, 0, 1, v, dv); chk("R6 held while in service", v, 0);
    wr(5, 2, 0, 1); idle(2);
    rd(2, 0, 1, v, dv); chk("R7 not enabled for ctx", v, 0);
    wr(5, 0, 0, 4); idle(1);
    rd(2, 0, 4, v, dv); chk("R7 never claimed", v, 0);
    // completion on a claimed level source that is still high
    wr(5, 0, 0, 3); idle(1);
    rd(2, 0, 3, v, dv); chk("R8 re-pend after completion", v, 1);
    wr(5, 0, 0, 1); idle(1);
    rd(2, 0, 1, v, dv); chk("R8 level re-pend", v, 1);
    irq_src = '0;

    // R9 / R10 / R11 edge handling
    do_reset();
    wr(1, 0, 4, 1); wr(0, 0, 4, 3); wr(3, 0, 4, 1);
    pulse(4);
    rd(2, 0, 4, v, dv); chk("R9 edge pending", v, 1);
    pulse(4);
    rd(5, 0, 0, v, dv); chk("R9 merged claim", v, 4); chk("R11 drop claim", dv, 4);
    rd(5, 0, 0, v, dv); chk("R9 merged once", v, 0);
    pulse(4); pulse(4); pulse(4);
    wr(5, 0, 0, 4); idle(1);
    rd(2, 0, 4, v, dv); chk("R10 queued re-pend", v, 1); chk("R11 dropped", dv, 0);
    rd(5, 0, 0, v, dv); chk("R10 claim 2", v, 4);
    wr(5, 0, 0, 4); idle(1);
    rd(5, 0, 0, v, dv); chk("R10 claim 3", v, 4);
    wr(5, 0, 0, 4); idle(1);
    rd(5, 0, 0, v, dv); chk("R10 saturated count", v, 0);
    chk("R11 drop line", int'(d_irq[0]), 0);
    // edge on the completion cycle itself
    rd(2, 0, 4, v, dv);
    pulse(4);
    rd(5, 0, 0, v, dv); chk("R9 fresh claim", v, 4);
    bus_addr = {3'd5, 4'd0, 5'd0}; bus_wdata = 32'd4; bus_wr = 1'b1; irq_src[4] = 1'b1;
    tick();
    bus_wr = 1'b0; irq_src[4] = 1'b0;
    idle(1);
    rd(2, 0, 4, v, dv); chk("R10 edge at completion", v, 1); chk("R11 edge at completion", dv, 1);

    // R12 absent context
    wr(3, 1, 4, 1); wr(4, 1, 0, 2);
    rd(4, 1, 0, v, dv); chk("R12 absent threshold", v, 0);
    rd(3, 1, 4, v, dv); chk("R12 absent enable", v, 0);
    rd(5, 1, 0, v, dv); chk("R12 absent claim", v, 0);
    idle(2);
    chk("R12 absent line", int'(irq_out[1]), 0);
    rd(2, 0, 4, v, dv); chk("R12 pending untouched", v, 1);

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule